// File: doc/BRIEF.md
# Periodic Timing Command Scheduler

This block produces a simulated stream of timing commands for a crate test setup that has no external timing source. It keeps a bunch-crossing counter that runs through a fixed orbit length and an orbit counter that advances each time the crossing counter wraps. A bunch-counter-reset command goes out once in every orbit. Software can also ask for an event-count-reset or an orbit-count-reset command, each with its own single-cycle strobe.

Four programmable channels add their own commands. Each channel holds a 32-bit command word, a long/short format flag, a crossing number, an orbit prescale and a single-shot flag. A periodic channel sends its command on its chosen crossing once every prescale+1 orbits. A single-shot channel sends only when the global single strobe arrives. At most one command leaves per clock. When several commands compete, the losers wait in pending flags and go out on the clocks that follow. Line encoding and serialisation happen downstream.

Top module: `timing_cmd_sched`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it is released, bxNum and orbitNum are 0 and cmdValid is 0.
- R2: bxNum counts up by one each clock from 0 to ORBIT_LEN-1 and then returns to 0. orbitNum increments by one on that wrap and holds its value at all other times.
- R3: Each clock in which bxNum is 0 leads to cmdValid=1, cmdWord=0x00000001 and cmdLong=0 on the following clock. This is the bunch-counter reset, and it is never deferred.
- R4: A channel in short format outputs {24'h0, word[7:0]} with cmdLong=0. A channel in long format outputs all 32 bits of its word with cmdLong=1.
- R5: A periodic channel (single flag 0) requests its command on each clock where bxNum equals its crossing setting and its orbit countdown is 0. The countdown then reloads with the prescale value, so the command repeats every prescale+1 orbits. A configuration write clears the countdown, so the first match after the write fires.
- R6: A channel whose single flag is 1 never fires periodically. Each singleStb pulse makes it send its command once.
- R7: When more than one configured channel has its single flag set, singleStb fires only the lowest-numbered of them.
- R8: A pulse on ecrStb sends the short command 0x03, and a pulse on ocrStb sends the short command 0x09. A clock with ecrStb high is always followed by a clock with cmdValid high.
- R9: The sources are served in a fixed order: bunch-counter reset, then event-count reset, then orbit-count reset, then channels 0 to 3. Only one command goes out per clock. Each deferred command leaves on a later clock in that same order.
- R10: A channel that has not been written since reset emits nothing.
- R11: A request from a source whose previous request is still pending merges with that request, so the command goes out only once.
- R12: The output is registered. A request seen on one clock edge shows up on cmdValid/cmdWord/cmdLong right after that edge, unless a higher-priority command defers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one bunch crossing |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Writes the cfg fields into channel cfgChan |
| cfgChan | input | CH_W (2) | Channel index for the write |
| cfgCmd | input | 32 | Command word |
| cfgLong | input | 1 | 1 selects long format |
| cfgSingle | input | 1 | 1 selects single-shot operation |
| cfgPrescale | input | PRESC_W (8) | Orbit prescale; period is value+1 orbits |
| cfgBx | input | BX_W (12) | Crossing on which the channel fires |
| singleStb | input | 1 | Fires the selected single-shot channel |
| ecrStb | input | 1 | Requests an event-count-reset command |
| ocrStb | input | 1 | Requests an orbit-count-reset command |
| bxNum | output | BX_W (12) | Current crossing number |
| orbitNum | output | ORBIT_W (32) | Current orbit number |
| cmdValid | output | 1 | A command is present this cycle |
| cmdWord | output | 32 | Command word (upper bits zero when short) |
| cmdLong | output | 1 | 1 when cmdWord is long format |

## Verification
The bench targets the collision at crossing 0. It strobes both resets there while channel 0 also sits on crossing 0, and expects 0x01, 0x03, 0x09 and then the channel word on four consecutive clocks. A broken priority encoder would reorder or drop commands. The bench also checks that two event-count-reset strobes on back-to-back clocks yield a single command when the first strobe was deferred, and that the single strobe with two single-shot channels fires only the lower one. A design that lost the countdown reload would fire the prescaled channel every orbit instead of every other orbit. Randomised reconfiguration and strobes are compared cycle by cycle with a bench model, which catches format truncation and off-by-one errors on crossings.

// File: rtl/timing_cmd_pkg.sv
package timing_cmd_pkg;
  localparam int CMD_W = 32;
  localparam int SHORT_W = 8;
  localparam int FIXED_SRC = 3;
  localparam logic [SHORT_W-1:0] BC0_CODE = 8'h01;
  localparam logic [SHORT_W-1:0] ECR_CODE = 8'h03;
  localparam logic [SHORT_W-1:0] OCR_CODE = 8'h09;

  // strobes from control to datapath for the fixed command sources
  typedef struct packed {
    logic ocrReq;
    logic ecrReq;
    logic bc0Req;
  } fixedReq_t;
endpackage

// File: rtl/timing_cmd_pick.sv
// Lowest-index-wins one-hot selector.
module timing_cmd_pick #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  assign grant = req & (~req + N'(1));
endmodule

// File: rtl/timing_cmd_ctrl.sv
module timing_cmd_ctrl
  import timing_cmd_pkg::*;
#(
  parameter int ORBIT_LEN = 3564,
  parameter int NUM_CH = 4,
  parameter int PRESC_W = 8,
  parameter int ORBIT_W = 32,
  localparam int BX_W = $clog2(ORBIT_LEN),
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [CH_W-1:0]    cfgChan,
  input  logic               cfgSingle,
  input  logic [PRESC_W-1:0] cfgPrescale,
  input  logic [BX_W-1:0]    cfgBx,
  input  logic               singleStb,
  input  logic               ecrStb,
  input  logic               ocrStb,
  output logic [BX_W-1:0]    bxNum,
  output logic [ORBIT_W-1:0] orbitNum,
  output fixedReq_t          fixedReq,
  output logic [NUM_CH-1:0]  chReq
);
  localparam logic [BX_W-1:0] LAST_BX = BX_W'(ORBIT_LEN - 1);

  logic [NUM_CH-1:0] singleCand;
  logic [NUM_CH-1:0] singleSel;

  // crossing and orbit counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bxNum    <= '0;
      orbitNum <= '0;
    end else if (bxNum == LAST_BX) begin
      bxNum    <= '0;
      orbitNum <= orbitNum + ORBIT_W'(1);
    end else begin
      bxNum <= bxNum + BX_W'(1);
    end
  end

  assign fixedReq.bc0Req = (bxNum == '0);
  assign fixedReq.ecrReq = ecrStb;
  assign fixedReq.ocrReq = ocrStb;

  // one-shot target: lowest configured single channel
  timing_cmd_pick #(.N(NUM_CH)) u_singlePick (
    .req  (singleCand),
    .grant(singleSel)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic               isConf;
    logic               isSingle;
    logic [BX_W-1:0]    atBx;
    logic [PRESC_W-1:0] prescVal;
    logic [PRESC_W-1:0] orbitLeft;
    logic               chWr;
    logic               bxHit;

    assign chWr  = cfgWe && (cfgChan == CH_W'(g));
    assign bxHit = isConf && !isSingle && (bxNum == atBx);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        isConf    <= 1'b0;
        isSingle  <= 1'b0;
        atBx      <= '0;
        prescVal  <= '0;
        orbitLeft <= '0;
      end else if (chWr) begin
        isConf    <= 1'b1;
        isSingle  <= cfgSingle;
        atBx      <= cfgBx;
        prescVal  <= cfgPrescale;
        orbitLeft <= '0;
      end else if (bxHit) begin
        orbitLeft <= (orbitLeft == '0) ? prescVal : orbitLeft - PRESC_W'(1);
      end
    end

    assign singleCand[g] = isConf && isSingle;
    assign chReq[g] = (bxHit && (orbitLeft == '0)) || (singleStb && singleSel[g]);
  end
endmodule

// File: rtl/timing_cmd_dp.sv
module timing_cmd_dp
  import timing_cmd_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SRC_N = FIXED_SRC + NUM_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgChan,
  input  logic [CMD_W-1:0]  cfgCmd,
  input  logic              cfgLong,
  input  fixedReq_t         fixedReq,
  input  logic [NUM_CH-1:0] chReq,
  output logic              cmdValid,
  output logic [CMD_W-1:0]  cmdWord,
  output logic              cmdLong
);
  logic [NUM_CH-1:0][CMD_W-1:0] chWord;
  logic [NUM_CH-1:0]            chLong;
  logic [SRC_N-1:0]             pend;
  logic [SRC_N-1:0]             reqAll;
  logic [SRC_N-1:0]             grant;
  logic [CMD_W-1:0]             nextWord;
  logic                         nextLong;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_store
    logic [CMD_W-1:0] wordReg;
    logic             longReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wordReg <= '0;
        longReg <= 1'b0;
      end else if (cfgWe && (cfgChan == CH_W'(g))) begin
        wordReg <= cfgCmd;
        longReg <= cfgLong;
      end
    end
    assign chWord[g] = wordReg;
    assign chLong[g] = longReg;
  end

  // bit 0 is the highest priority
  assign reqAll = pend | {chReq, fixedReq.ocrReq, fixedReq.ecrReq, fixedReq.bc0Req};

  timing_cmd_pick #(.N(SRC_N)) u_srcPick (
    .req  (reqAll),
    .grant(grant)
  );

  always_comb begin
    nextWord = '0;
    nextLong = 1'b0;
    if (grant[0]) nextWord = CMD_W'(BC0_CODE);
    if (grant[1]) nextWord = CMD_W'(ECR_CODE);
    if (grant[2]) nextWord = CMD_W'(OCR_CODE);
    for (int i = 0; i < NUM_CH; i++) begin
      if (grant[FIXED_SRC+i]) begin
        nextLong = chLong[i];
        nextWord = chLong[i] ? chWord[i] : CMD_W'(chWord[i][SHORT_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= '0;
      cmdValid <= 1'b0;
      cmdWord  <= '0;
      cmdLong  <= 1'b0;
    end else begin
      pend     <= reqAll & ~grant;
      cmdValid <= |reqAll;
      cmdWord  <= nextWord;
      cmdLong  <= nextLong;
    end
  end
endmodule

// File: rtl/timing_cmd_sched.sv
module timing_cmd_sched
  import timing_cmd_pkg::*;
#(
  parameter int ORBIT_LEN = 3564,
  parameter int NUM_CH = 4,
  parameter int PRESC_W = 8,
  parameter int ORBIT_W = 32,
  localparam int BX_W = $clog2(ORBIT_LEN),
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [CH_W-1:0]    cfgChan,
  input  logic [31:0]        cfgCmd,
  input  logic               cfgLong,
  input  logic               cfgSingle,
  input  logic [PRESC_W-1:0] cfgPrescale,
  input  logic [BX_W-1:0]    cfgBx,
  input  logic               singleStb,
  input  logic               ecrStb,
  input  logic               ocrStb,
  output logic [BX_W-1:0]    bxNum,
  output logic [ORBIT_W-1:0] orbitNum,
  output logic               cmdValid,
  output logic [31:0]        cmdWord,
  output logic               cmdLong
);
  fixedReq_t         fixedReq;
  logic [NUM_CH-1:0] chReq;

  timing_cmd_ctrl #(
    .ORBIT_LEN(ORBIT_LEN),
    .NUM_CH   (NUM_CH),
    .PRESC_W  (PRESC_W),
    .ORBIT_W  (ORBIT_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgChan    (cfgChan),
    .cfgSingle  (cfgSingle),
    .cfgPrescale(cfgPrescale),
    .cfgBx      (cfgBx),
    .singleStb  (singleStb),
    .ecrStb     (ecrStb),
    .ocrStb     (ocrStb),
    .bxNum      (bxNum),
    .orbitNum   (orbitNum),
    .fixedReq   (fixedReq),
    .chReq      (chReq)
  );

  timing_cmd_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgChan (cfgChan),
    .cfgCmd  (cfgCmd),
    .cfgLong (cfgLong),
    .fixedReq(fixedReq),
    .chReq   (chReq),
    .cmdValid(cmdValid),
    .cmdWord (cmdWord),
    .cmdLong (cmdLong)
  );
endmodule

// File: rtl/timing_cmd_sched_chk.sv
module timing_cmd_sched_chk #(
  parameter int ORBIT_LEN = 3564,
  parameter int ORBIT_W = 32,
  localparam int BX_W = $clog2(ORBIT_LEN)
) (
  input logic               clk,
  input logic               rstN,
  input logic               ecrStb,
  input logic [BX_W-1:0]    bxNum,
  input logic [ORBIT_W-1:0] orbitNum,
  input logic               cmdValid,
  input logic [31:0]        cmdWord,
  input logic               cmdLong
);
  localparam logic [BX_W-1:0] LAST_BX = BX_W'(ORBIT_LEN - 1);

  a_r2_bx_bound: assert property (@(posedge clk) disable iff (!rstN)
    bxNum <= LAST_BX);

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (bxNum == LAST_BX) |=> (bxNum == '0) && (orbitNum == ORBIT_W'($past(orbitNum) + 1'b1)));

  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (bxNum != LAST_BX) |=> (bxNum == BX_W'($past(bxNum) + 1'b1)) && $stable(orbitNum));

  a_r3_bc0_each_orbit: assert property (@(posedge clk) disable iff (!rstN)
    (bxNum == '0) |=> cmdValid && (cmdWord == 32'h1) && !cmdLong);

  a_r4_short_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdLong) |-> (cmdWord[31:8] == 24'h0));

  a_r8_ecr_served: assert property (@(posedge clk) disable iff (!rstN)
    ecrStb |=> cmdValid);
endmodule

bind timing_cmd_sched timing_cmd_sched_chk #(
  .ORBIT_LEN(ORBIT_LEN),
  .ORBIT_W  (ORBIT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ecrStb  (ecrStb),
  .bxNum   (bxNum),
  .orbitNum(orbitNum),
  .cmdValid(cmdValid),
  .cmdWord (cmdWord),
  .cmdLong (cmdLong)
);

// File: tb/timing_cmd_sched_bench.sv
module timing_cmd_sched_bench;
  localparam int L = 100;
  localparam int NCH = 4;
  localparam int PW = 8;
  localparam int OW = 16;
  localparam int BXW = $clog2(L);

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           cfgWe = 1'b0;
  logic [1:0]     cfgChan = '0;
  logic [31:0]    cfgCmd = '0;
  logic           cfgLong = 1'b0;
  logic           cfgSingle = 1'b0;
  logic [PW-1:0]  cfgPrescale = '0;
  logic [BXW-1:0] cfgBx = '0;
  logic           singleStb = 1'b0;
  logic           ecrStb = 1'b0;
  logic           ocrStb = 1'b0;
  logic [BXW-1:0] bxNum;
  logic [OW-1:0]  orbitNum;
  logic           cmdValid;
  logic [31:0]    cmdWord;
  logic           cmdLong;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  timing_cmd_sched #(.ORBIT_LEN(L), .NUM_CH(NCH), .PRESC_W(PW), .ORBIT_W(OW)) u_timing_cmd_sched (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgChan(cfgChan), .cfgCmd(cfgCmd),
    .cfgLong(cfgLong), .cfgSingle(cfgSingle), .cfgPrescale(cfgPrescale), .cfgBx(cfgBx),
    .singleStb(singleStb), .ecrStb(ecrStb), .ocrStb(ocrStb), .bxNum(bxNum),
    .orbitNum(orbitNum), .cmdValid(cmdValid), .cmdWord(cmdWord), .cmdLong(cmdLong)
  );

  // ---------------- reference model from the requirements ----------------
  int          mBx, mOrb;
  bit          mConf[NCH], mSingle[NCH], mLong[NCH];
  int          mAt[NCH], mPre[NCH], mLeft[NCH];
  logic [31:0] mWord[NCH];
  bit [6:0]    mPend;
  bit          eValid;
  logic [31:0] eWord;
  bit          eLong;
  string       eTag;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBx = 0; mOrb = 0; mPend = '0; eValid = 0; eWord = '0; eLong = 0; eTag = "R1";
      for (int i = 0; i < NCH; i++) begin
        mConf[i] = 0; mSingle[i] = 0; mLong[i] = 0; mAt[i] = 0; mPre[i] = 0; mLeft[i] = 0; mWord[i] = '0;
      end
    end else begin
      bit [6:0] req, all, gr;
      bit seen;
      int src;
      req = '0;
      req[0] = (mBx == 0);
      req[1] = ecrStb;
      req[2] = ocrStb;
      seen = 0;
      for (int i = 0; i < NCH; i++)
        if (mConf[i] && mSingle[i] && !seen) begin seen = 1; if (singleStb) req[3+i] = 1; end
      for (int i = 0; i < NCH; i++)
        if (mConf[i] && !mSingle[i] && mBx == mAt[i]) begin
          if (mLeft[i] == 0) begin req[3+i] = 1; mLeft[i] = mPre[i]; end
          else mLeft[i] = mLeft[i] - 1;
        end
      all = mPend | req;
      gr = '0; src = -1;
      for (int k = 0; k < 7; k++) if (all[k] && src < 0) begin gr[k] = 1; src = k; end
      eValid = (all != 0); eWord = '0; eLong = 0; eTag = "R12";
      if (src == 0) begin eWord = 32'h01; eTag = "R3"; end
      if (src == 1) begin eWord = 32'h03; eTag = "R8"; end
      if (src == 2) begin eWord = 32'h09; eTag = "R8"; end
      if (src >= 3) begin
        eLong = mLong[src-3];
        eWord = mLong[src-3] ? mWord[src-3] : {24'h0, mWord[src-3][7:0]};
        eTag = mSingle[src-3] ? "R4 R6" : "R4 R5";
      end
      if ($countones(all) > 1) eTag = {"R9 R11 ", eTag};
      mPend = all & ~gr;
      if (cfgWe) begin
        mConf[cfgChan] = 1; mSingle[cfgChan] = cfgSingle; mLong[cfgChan] = cfgLong;
        mAt[cfgChan] = int'(cfgBx); mPre[cfgChan] = int'(cfgPrescale);
        mLeft[cfgChan] = 0; mWord[cfgChan] = cfgCmd;
      end
      if (mBx == L - 1) begin mBx = 0; mOrb = mOrb + 1; end
      else mBx = mBx + 1;
    end
  end

  // ---------------- cycle monitor ----------------
  int cyc = 0;
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (eValid || cmdValid) begin
        total++;
        if (cmdValid !== eValid || cmdWord !== eWord || cmdLong !== eLong) begin
          bad++;
          $display("FAIL %s cmd act v=%0b w=%h l=%0b exp v=%0b w=%h l=%0b",
                   eTag, cmdValid, cmdWord, cmdLong, eValid, eWord, eLong);
        end
      end
      if (cyc % 16 == 0) begin
        total++;
        if (int'(bxNum) != mBx || orbitNum != OW'(mOrb)) begin
          bad++;
          $display("FAIL R2 counters act bx=%0d orb=%0d exp bx=%0d orb=%0d", bxNum, orbitNum, mBx, mOrb);
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input logic [31:0] w, input bit lng, input bit sgl,
                     input int bx, input int pre);
    cfgWe = 1; cfgChan = 2'(ch); cfgCmd = w; cfgLong = lng; cfgSingle = sgl;
    cfgBx = BXW'(bx); cfgPrescale = PW'(pre);
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic waitBx(input int v);
    while (int'(bxNum) != v) @(negedge clk);
  endtask

  // counts outputs from the current negedge on, over n negedges
  task automatic watch(input int n, input logic [31:0] w, output int hits, output int anyV);
    hits = 0; anyV = 0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      if (cmdValid) anyV++;
      if (cmdValid && cmdWord == w) hits++;
    end
  endtask

  logic [31:0] capBuf[8];
  int capN;
  task automatic capture(input int n);
    capN = 0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      if (cmdValid && capN < 8) begin capBuf[capN] = cmdWord; capN++; end
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finishRun();
  end

  initial begin
    int h, a, h2, a2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 bxNum", bxNum, 0);
    chk("R1 orbitNum", orbitNum, 0);
    chk("R1 cmdValid", cmdValid, 0);
    rstN = 1;
    @(negedge clk);

    // R10 and R3: only the bunch-counter reset during the first orbit
    watch(L, 32'h1, h, a);
    chk("R3 one bc0 per orbit", h, 1);
    chk("R10 unconfigured silent", a - h, 0);

    // channel setup
    cfg(0, 32'hDEADBE5A, 0, 0, 0, 0);
    cfg(1, 32'h12345678, 1, 0, 20, 1);
    cfg(2, 32'hCAFE0077, 1, 1, 40, 0);
    cfg(3, 32'h000000C3, 0, 1, 40, 0);

    // R9 + R8 + R4: collision at crossing 0
    waitBx(0);
    ecrStb = 1; ocrStb = 1;
    @(negedge clk);
    ecrStb = 0; ocrStb = 0;
    capture(6);
    chk("R9 count", capN, 4);
    chk("R9 R3 first", capBuf[0], 32'h01);
    chk("R9 R8 ecr second", capBuf[1], 32'h03);
    chk("R9 R8 ocr third", capBuf[2], 32'h09);
    chk("R9 R4 short channel", capBuf[3], 32'h5A);

    // R5: prescale 1 on channel 1 fires every other orbit; R6 singles stay quiet
    waitBx(50);
    watch(4 * L, 32'h12345678, h, a);
    chk("R5 prescaled count", h, 2);
    watch(1, 32'hCAFE0077, h, a);
    watch(3 * L, 32'hCAFE0077, h, a);
    watch(1, 32'hC3, h2, a2);
    chk("R6 no periodic fire", h, 0);

    // R7: single strobe picks only channel 2
    waitBx(60);
    singleStb = 1;
    @(negedge clk);
    singleStb = 0;
    watch(10, 32'hCAFE0077, h, a);
    chk("R7 R6 lowest single fires", h, 1);
    waitBx(60);
    singleStb = 1;
    @(negedge clk);
    singleStb = 0;
    watch(10, 32'hC3, h, a);
    chk("R7 higher single silent", h, 0);

    // R11: back-to-back ecr with first deferred by bc0
    waitBx(0);
    ecrStb = 1;
    @(negedge clk);
    @(negedge clk);
    ecrStb = 0;
    watch(6, 32'h03, h, a);
    chk("R11 merged ecr", h, 1);

    // R4 long word seen in full
    waitBx(15);
    watch(2 * L, 32'h12345678, h, a);
    chk("R4 long word intact", h, 1);

    // randomised phase, checked by the cycle monitor
    for (int c = 0; c < 6000; c++) begin
      cfgWe = ($urandom_range(39) == 0);
      cfgChan = 2'($urandom_range(3));
      cfgCmd = $urandom;
      cfgLong = $urandom_range(1) == 1;
      cfgSingle = ($urandom_range(2) == 0);
      cfgBx = BXW'($urandom_range(L - 1));
      cfgPrescale = PW'($urandom_range(3));
      ecrStb = ($urandom_range(49) == 0);
      ocrStb = ($urandom_range(49) == 0);
      singleStb = ($urandom_range(59) == 0);
      @(negedge clk);
    end
    cfgWe = 0; ecrStb = 0; ocrStb = 0; singleStb = 0;
    repeat (20) @(negedge clk);
    chk("R2 orbit after run", orbitNum, OW'(mOrb));
    finishRun();
  end
endmodule